// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to sixteen interrupt inputs and drives a single request line to a host processor. Every input passes through a synchronizer and a rising-edge detector. A detected edge latches a pending flag for that input. A per-input enable bit decides whether the pending flag reaches the request line. Masking only gates the request line: pending flags are never lost or changed by a mask write, so an event that arrives while its input is disabled still raises the request once the input is enabled.

Software controls the block through a write-only port with four offsets, held in a 2-bit offset field:

| Offset | Action |
|--------|--------|
| 0 | Clear selected pending flags |
| 1 | Disable selected inputs |
| 2 | Enable selected inputs |
| 3 | Load the 8-bit vector code for one input |

When the processor supplies its own vector numbers, the request line and the software clear are all it needs. When it expects the peripheral to supply a vector, it raises an acknowledge pulse. The block then picks the lowest-numbered input that is both pending and enabled. It returns that input's vector on an 8-bit output and clears that input's pending flag in the same step.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0x00, every enable bit is 0 and every stored vector is 0x00.
- R2: A pending flag is set only by a low-to-high transition of its input, seen through the two-stage synchronizer. An input that stays high after its flag has been cleared does not set the flag again.
- R3: A write to offset 0 clears each pending flag whose data bit is 1. Flags whose data bit is 0 are unaffected.
- R4: A write to offset 1 clears each enable bit whose data bit is 1. A write to offset 2 sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R5: Enable and disable writes never change any pending flag. A flag that was set while its input was disabled raises `irq_o` as soon as the input is enabled.
- R6: `irq_o` is 1 exactly when at least one input is both pending and enabled.
- R7: A write to offset 3 stores data bits [7:0] as the vector for the input numbered by data bits [11:8].
- R8: On the first cycle of a high level on `ack_i`, the block selects the lowest-numbered input that is pending and enabled. At the following clock edge, `vec_o` takes that input's vector. `vec_o` then holds its value until the next acknowledge begins, even if new requests arrive meanwhile.
- R9: An acknowledge clears the pending flag of the selected input only. Other pending flags stay set.
- R10: An acknowledge that finds no input both pending and enabled sets `vec_o` to 0x00. It leaves all pending flags unchanged, including those of disabled inputs.
- R11: When a new edge on an input coincides with a clear of that same input, the set wins and the flag stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 16 | Interrupt inputs, may be asynchronous |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_off_i | input | 2 | Register offset: 0 clear, 1 disable, 2 enable, 3 vector |
| wr_data_i | input | 16 | Write data (one bit per input; for a vector write, [11:8] selects the input and [7:0] is the code) |
| ack_i | input | 1 | Interrupt-acknowledge level; its rising edge starts a vector cycle |
| irq_o | output | 1 | Request to the processor |
| vec_o | output | 8 | Vector of the last acknowledged input |

## Verification
The request path is driven with single edges on disabled inputs, on enabled inputs, and on an input held high. These separate edge capture from level capture, and masking from discarding. Acknowledges are issued with two enabled requests pending, which checks the priority order and that only the winner is cleared. They are also issued with a new request arriving mid-pulse, which checks that the output holds, and with only disabled requests pending, which checks the empty response. A clear write is placed on the exact cycle a fresh edge is detected, which shows whether the set wins over the clear.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    REG_CLR = 2'd0,
    REG_DIS = 2'd1,
    REG_ENA = 2'd2,
    REG_VEC = 2'd3
  } reg_off_e;

  // one-hot decode of a source number
  function automatic logic [31:0] idx_to_bit(input logic [4:0] idx);
    logic [31:0] r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/vic_edge_sync.sv
module vic_edge_sync #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] rise_o
);
  logic [NSRC-1:0] meta_q, sync_q, prev_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= src_i[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end
    assign rise_o[g] = sync_q[g] & ~prev_q[g];
  end
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int NSRC = 16,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req_i,
  output logic [IW-1:0]   idx_o,
  output logic            found_o
);
  function automatic logic [IW:0] lowest_one(input logic [NSRC-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IW'(i)};
    end
    return r;
  endfunction

  logic [IW:0] pick_w;
  assign pick_w  = lowest_one(req_i);
  assign found_o = pick_w[IW];
  assign idx_o   = pick_w[IW-1:0];
endmodule

// File: rtl/vic_vector_file.sv
module vic_vector_file #(
  parameter int NSRC = 16,
  parameter int VW   = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] wsel_i,
  input  logic [VW-1:0] wdata_i,
  input  logic [IW-1:0] rsel_i,
  output logic [VW-1:0] rdata_o
);
  logic [VW-1:0] vec_q [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rst_n)                               vec_q[g] <= '0;
      else if (we_i && (wsel_i == IW'(g)))      vec_q[g] <= wdata_i;
    end
  end

  assign rdata_o = vec_q[rsel_i];
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC = 16,
  parameter int VW   = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int DW = (NSRC > VW + IW) ? NSRC : VW + IW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_off_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [VW-1:0]   vec_o
);
  import vic_pkg::*;

  logic [NSRC-1:0] pend_q, mask_q, rise_w, clr_w, ack_clr_w, sw_clr_w;
  logic [NSRC-1:0] active_w, wr_bits_w;
  logic            ack_q, ack_start_w, pick_ok_w, vec_we_w;
  logic [IW-1:0]   pick_idx_w;
  logic [VW-1:0]   vec_rd_w, vec_q;
  reg_off_e        off_w;

  assign off_w     = reg_off_e'(wr_off_i);
  assign wr_bits_w = wr_data_i[NSRC-1:0];

  vic_edge_sync #(.NSRC(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise_w)
  );

  assign active_w = pend_q & mask_q;

  vic_prio_pick #(.NSRC(NSRC)) u_pick (
    .req_i(active_w), .idx_o(pick_idx_w), .found_o(pick_ok_w)
  );

  assign vec_we_w = wr_en_i && (off_w == REG_VEC) &&
                    (int'(wr_data_i[VW+IW-1:VW]) < NSRC);

  vic_vector_file #(.NSRC(NSRC), .VW(VW)) u_vfile (
    .clk(clk), .rst_n(rst_n), .we_i(vec_we_w),
    .wsel_i(wr_data_i[VW+IW-1:VW]), .wdata_i(wr_data_i[VW-1:0]),
    .rsel_i(pick_idx_w), .rdata_o(vec_rd_w)
  );

  assign ack_start_w = ack_i & ~ack_q;
  assign ack_clr_w   = (ack_start_w && pick_ok_w) ?
                       NSRC'(idx_to_bit(5'(pick_idx_w))) : '0;
  assign sw_clr_w    = (wr_en_i && off_w == REG_CLR) ? wr_bits_w : '0;
  assign clr_w       = sw_clr_w | ack_clr_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      // set has priority over any clear of the same source
      pend_q <= (pend_q & ~clr_w) | rise_w;
      if (wr_en_i && off_w == REG_DIS) mask_q <= mask_q & ~wr_bits_w;
      else if (wr_en_i && off_w == REG_ENA) mask_q <= mask_q | wr_bits_w;
      ack_q <= ack_i;
      if (ack_start_w) vec_q <= pick_ok_w ? vec_rd_w : '0;
    end
  end

  assign irq_o = |active_w;
  assign vec_o = vec_q;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NSRC = 16,
  parameter int VW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en_i,
  input logic [1:0]      wr_off_i,
  input logic [NSRC-1:0] wr_bits_w,
  input logic [VW-1:0]   vec_o,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] rise_w,
  input logic [NSRC-1:0] clr_w,
  input logic [NSRC-1:0] ack_clr_w,
  input logic            ack_start_w
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '0 && pend_q == '0 && vec_o == '0));

  a_r3_only_selected_change: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q ^ $past(pend_q)) & ~$past(rise_w | clr_w)) == '0);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> (pend_q & $past(rise_w)) == $past(rise_w));

  a_r5_mask_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_off_i == 2'd1 || wr_off_i == 2'd2) && !ack_start_w)
      |=> pend_q == ($past(pend_q) | $past(rise_w)));

  a_r4_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_off_i == 2'd2) |=> (mask_q & $past(wr_bits_w)) == $past(wr_bits_w));

  a_r4_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_off_i == 2'd1) |=> (mask_q & $past(wr_bits_w)) == '0);

  a_r9_single_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start_w |-> $onehot0(ack_clr_w));

  a_r8_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_start_w |=> $stable(vec_o));
endmodule

bind vec_irq_ctrl vic_checker #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_off_i(wr_off_i),
  .wr_bits_w(wr_bits_w), .vec_o(vec_o), .pend_q(pend_q), .mask_q(mask_q),
  .rise_w(rise_w), .clr_w(clr_w), .ack_clr_w(ack_clr_w),
  .ack_start_w(ack_start_w)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_off = '0;
  logic [15:0] wr_data = '0;
  logic        ack = 1'b0;
  logic        irq;
  logic [7:0]  vec;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .wr_off_i(wr_off),
    .wr_data_i(wr_data), .ack_i(ack), .irq_o(irq), .vec_o(vec)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] off, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_src(input int i);
    @(negedge clk);
    src[i] = 1'b1;
    repeat (4) @(negedge clk);
    src[i] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tidy();
    reg_wr(2'd1, 16'hFFFF);
    reg_wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 vec", vec, 8'h00);
    pulse_src(1);
    check("R1 mask default off", {7'd0, irq}, 8'd0);
    tidy();
  endtask

  task automatic t_mask();
    pulse_src(3);
    check("R5 masked request silent", {7'd0, irq}, 8'd0);
    reg_wr(2'd2, 16'h0008);
    check("R5 R6 request after enable", {7'd0, irq}, 8'd1);
    reg_wr(2'd1, 16'h0008);
    check("R4 disable drops irq", {7'd0, irq}, 8'd0);
    reg_wr(2'd2, 16'h0008);
    check("R5 pending kept across mask", {7'd0, irq}, 8'd1);
    reg_wr(2'd0, 16'h0010);
    check("R3 zero bit unaffected", {7'd0, irq}, 8'd1);
    reg_wr(2'd0, 16'h0008);
    check("R3 selected bit cleared", {7'd0, irq}, 8'd0);
    tidy();
  endtask

  task automatic t_level();
    reg_wr(2'd2, 16'h0400);
    @(negedge clk); src[10] = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 edge sets pending", {7'd0, irq}, 8'd1);
    reg_wr(2'd0, 16'h0400);
    repeat (3) @(negedge clk);
    check("R2 held level no reset", {7'd0, irq}, 8'd0);
    src[10] = 1'b0;
    repeat (4) @(negedge clk);
    tidy();
  endtask

  task automatic t_vector();
    reg_wr(2'd3, 16'h0011);  // src 0
    reg_wr(2'd3, 16'h02A5);  // src 2
    reg_wr(2'd3, 16'h075C);  // src 7
    reg_wr(2'd3, 16'h0FE3);  // src 15
    reg_wr(2'd2, 16'h8085);
    pulse_src(7);
    pulse_src(2);
    @(negedge clk); ack = 1'b1;
    @(negedge clk);
    check("R8 R7 lowest index vector", vec, 8'hA5);
    src[0] = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 vector held during ack", vec, 8'hA5);
    ack = 1'b0; src[0] = 1'b0;
    @(negedge clk);
    check("R9 others still pending", {7'd0, irq}, 8'd1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R8 next picks source 0", vec, 8'h11);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R8 then source 7", vec, 8'h5C);
    check("R9 ack cleared all served", {7'd0, irq}, 8'd0);
    pulse_src(15);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R7 highest source vector", vec, 8'hE3);
    tidy();
  endtask

  task automatic t_empty();
    pulse_src(9);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R10 empty ack vector", vec, 8'h00);
    reg_wr(2'd2, 16'h0200);
    check("R10 masked pending survives ack", {7'd0, irq}, 8'd1);
    tidy();
  endtask

  task automatic t_collide();
    reg_wr(2'd2, 16'h0040);
    pulse_src(6);
    @(negedge clk); src[6] = 1'b1;      // before edge k
    @(negedge clk);                     // after k: first flop
    @(negedge clk);                     // after k+1: edge detected
    wr_en = 1'b1; wr_off = 2'd0; wr_data = 16'h0040;
    @(negedge clk); wr_en = 1'b0;       // after k+2: set and clear met
    check("R11 set beats clear", {7'd0, irq}, 8'd1);
    reg_wr(2'd0, 16'h0040);
    check("R11 later clear works", {7'd0, irq}, 8'd0);
    src[6] = 1'b0;
    repeat (4) @(negedge clk);
    tidy();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_level();
    t_vector();
    t_empty();
    t_collide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule